// File: doc/BRIEF.md
# Tick-Driven Periodic and Programmable Interrupt Timer

This block turns a periodic tick enable into the timing interrupts of a small CPU system. A free-running 14-bit tick counter advances on every tick while the oscillator enable is set. Its low bits produce three fixed-rate strobes:

- a level-1 interrupt every 64 ticks;
- a keyboard-scan strobe every 128 ticks;
- an optional level-3 interrupt every 16384 ticks.

An 8-bit programmable counter steps at one of four prescaled rates. When a step finds the counter at zero, the counter reloads from a value that software wrote. A level-5 interrupt fires on a step that leaves the counter at zero.

Software sees two byte registers through a one-bit select:

- Select 0 is the control register.
- Select 1 is the counter register. A write sets the reload value. A read returns the live counter.

Every output strobe is registered. It goes high for exactly one clock, in the cycle after the tick that caused it. Interrupt priority and acknowledgement are handled elsewhere.

Top module: `tick_irq_timer`

## Requirements
- R1: After reset the control register, the reload value, the live counter and the tick count are all zero, all four strobes are low, and both registers read back 0x00.
- R2: A write with `wr_sel`=0 replaces the control register, and reading with `rd_sel`=0 returns it unchanged. A write with `wr_sel`=1 sets only the reload value; reading with `rd_sel`=1 returns the live counter, never the reload value.
- R3: Control bit 1 is the oscillator enable. While it is clear, ticks advance neither the tick count nor the programmable counter, and no strobe of any kind is produced.
- R4: Each enabled tick (tick high, bit 1 set) adds one to the tick count. An enabled tick that brings the count to a multiple of 64 pulses `irq_l1` high for the next clock, unless control bit 7 is set.
- R5: An enabled tick that wraps the 14-bit tick count to zero (every 16384 enabled ticks) pulses `irq_l3`, provided control bit 2 is set and bit 7 is clear.
- R6: An enabled tick that brings the tick count to a multiple of 128 pulses `kbd_scan`. Control bit 7 does not suppress this strobe.
- R7: Control bit 3 enables counter steps, and bits 5..4 select the step period. The selections 0, 1, 2 and 3 give a step on an enabled tick whose new tick count is a multiple of 1, 4, 16 or 64 respectively.
- R8: On a step, a counter at 0x00 is loaded with the reload value; any other value increments by one, so 0xFF becomes 0x00. A reload value written in the same cycle as a reload takes effect only from the next reload.
- R9: `irq_l5` pulses for one clock after a step that leaves the counter at 0x00, unless control bit 7 is set. It never pulses in a cycle without a step.
- R10: Control bit 7 only suppresses `irq_l1`, `irq_l3` and `irq_l5`. The tick count and the programmable counter keep advancing while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Tick enable, one cycle per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write select: 0 control, 1 counter reload |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 live counter |
| rd_data | output | 8 | Read data (combinational) |
| irq_l1 | output | 1 | Level-1 interrupt strobe |
| irq_l3 | output | 1 | Level-3 interrupt strobe |
| irq_l5 | output | 1 | Level-5 interrupt strobe |
| kbd_scan | output | 1 | Keyboard-scan strobe |

## Verification
The level-3 strobe is the hardest event to reach. It needs 16384 enabled ticks with bit 2 set and bit 7 clear at the moment the tick count wraps. A random mix of control writes would almost never hold those conditions that long.

The bench therefore runs a directed stretch with the tick held high and a fixed control value well past one wrap. Random phases follow that toggle the oscillator, the mask and the prescaler. Counter wrap and reload cases are reached by writing reload values close to 0xFF and zero with the fastest prescaler.

// File: rtl/tick_irq_timer.sv
module tick_irq_timer #(
  parameter int TICK_W  = 14,
  parameter int DATA_W  = 8,
  parameter int L1_LOG  = 6,
  parameter int KBD_LOG = 7,
  parameter int PS_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_l1,
  output logic              irq_l3,
  output logic              irq_l5,
  output logic              kbd_scan
);

  localparam int MASK_BIT = 7;
  localparam int PS_LO    = 4;
  localparam int CNT_EN   = 3;
  localparam int L3_EN    = 2;
  localparam int OSC_EN   = 1;

  logic [DATA_W-1:0] ctrl, reload, pcnt, pnext;
  logic [TICK_W-1:0] tcnt, tnext, pmask;
  logic              step, pinc, masked;
  logic [1:0]        psel;

  assign masked = ctrl[MASK_BIT];
  assign psel   = ctrl[PS_LO+1:PS_LO];
  assign step   = tick & ctrl[OSC_EN];
  assign tnext  = tcnt + 1'b1;

  always_comb begin
    int sh;
    sh    = PS_STEP * int'(psel);
    pmask = TICK_W'((32'd1 << sh) - 32'd1);
  end

  assign pinc    = step & ctrl[CNT_EN] & ((tnext & pmask) == '0);
  assign pnext   = (pcnt == '0) ? reload : pcnt + 1'b1;
  assign rd_data = rd_sel ? pcnt : ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      reload   <= '0;
      pcnt     <= '0;
      tcnt     <= '0;
      irq_l1   <= 1'b0;
      irq_l3   <= 1'b0;
      irq_l5   <= 1'b0;
      kbd_scan <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) ctrl   <= wr_data;
      if (wr_en &&  wr_sel) reload <= wr_data;
      if (step) tcnt <= tnext;
      if (pinc) pcnt <= pnext;
      irq_l1   <= step & ~masked & (tnext[L1_LOG-1:0] == '0);
      irq_l3   <= step & ~masked & ctrl[L3_EN] & (tnext == '0);
      kbd_scan <= step & (tnext[KBD_LOG-1:0] == '0);
      irq_l5   <= pinc & ~masked & (pnext == '0);
    end
  end

  p_l1_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l1 |-> (tcnt[L1_LOG-1:0] == '0 && !$past(ctrl[MASK_BIT])));

  p_l3_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l3 |-> (tcnt == '0 && $past(ctrl[L3_EN]) && !$past(ctrl[MASK_BIT])));

  p_kbd_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_scan |-> tcnt[KBD_LOG-1:0] == '0);

  p_l5_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l5 |-> (pcnt == '0 && !$past(ctrl[MASK_BIT])));

  p_osc_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[OSC_EN] |=> (!irq_l1 && !irq_l3 && !irq_l5 && !kbd_scan && $stable(tcnt) && $stable(pcnt)));

  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tcnt));

endmodule

// File: tb/test_tick_irq_timer.sv
`timescale 1ns/1ps
module test_tick_irq_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq_l1, irq_l3, irq_l5, kbd_scan;

  tick_irq_timer i_tick_irq_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_l1(irq_l1), .irq_l3(irq_l3), .irq_l5(irq_l5), .kbd_scan(kbd_scan));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, l3_seen = 0, l5_seen = 0;
  logic [7:0] m_ctrl = 0, m_rel = 0, m_cnt = 0;
  logic [13:0] m_tick = 0;

  function automatic logic [13:0] ps_mask(input logic [1:0] s);
    case (s)
      2'd0: ps_mask = 14'd0;
      2'd1: ps_mask = 14'd3;
      2'd2: ps_mask = 14'd15;
      default: ps_mask = 14'd63;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit we, input bit ws, input logic [7:0] wd);
    bit en, st, e1, e3, e5, ek;
    logic [13:0] nt;
    logic [7:0] nc;
    @(negedge clk);
    tick = tk; wr_en = we; wr_sel = ws; wr_data = wd;
    en = tk && m_ctrl[1];
    nt = m_tick + 14'd1;
    st = en && m_ctrl[3] && ((nt & ps_mask(m_ctrl[5:4])) == 0);
    nc = (m_cnt == 0) ? m_rel : m_cnt + 8'd1;
    e1 = en && !m_ctrl[7] && nt[5:0] == 0;
    e3 = en && !m_ctrl[7] && m_ctrl[2] && nt == 0;
    ek = en && nt[6:0] == 0;
    e5 = st && !m_ctrl[7] && nc == 0;
    if (en) m_tick = nt;
    if (st) m_cnt = nc;
    if (we && !ws) m_ctrl = wd;
    if (we && ws) m_rel = wd;
    @(posedge clk); #1;
    tick = 0; wr_en = 0;
    chk(irq_l1 == e1, "R4 irq_l1", irq_l1, e1);
    chk(irq_l3 == e3, "R5 irq_l3", irq_l3, e3);
    chk(kbd_scan == ek, "R6 kbd_scan", kbd_scan, ek);
    chk(irq_l5 == e5, "R9 irq_l5", irq_l5, e5);
    if (e3) l3_seen++;
    if (e5) l5_seen++;
    rd_sel = 1; #1;
    chk(rd_data == m_cnt, "R8 live counter", rd_data, m_cnt);
    rd_sel = 0; #1;
    chk(rd_data == m_ctrl, "R2 control readback", rd_data, m_ctrl);
  endtask

  task automatic run(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(tk, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk({irq_l1, irq_l3, irq_l5, kbd_scan} == 0, "R1 strobes low", {irq_l1, irq_l3, irq_l5, kbd_scan}, 0);
    rd_sel = 1; #1 chk(rd_data == 0, "R1 counter zero", rd_data, 0);
    rd_sel = 0; #1 chk(rd_data == 0, "R1 control zero", rd_data, 0);

    // R3: oscillator off, ticks ignored
    cyc(0, 1, 1, 8'hFC);
    cyc(0, 1, 0, 8'h0C);
    run(200, 1);
    rd_sel = 1; #1 chk(rd_data == 0, "R3 counter held with osc off", rd_data, 0);
    chk(l5_seen == 0, "R3 no level-5 with osc off", l5_seen, 0);

    // R2: reload write does not touch live counter
    cyc(0, 1, 0, 8'h0A);
    cyc(0, 1, 1, 8'h55);
    rd_sel = 1; #1 chk(rd_data == 0, "R2 reload write not visible", rd_data, 0);

    // R8/R9: wrap from 0xFF with reload near top
    cyc(0, 1, 1, 8'hFD);
    run(20, 1);
    chk(l5_seen >= 4, "R9 level-5 occurrences", l5_seen, 4);

    // R8: reload of zero keeps counter at zero, firing every step
    cyc(0, 1, 1, 8'h00);
    run(10, 1);

    // R7: prescaler 2 (every 16 ticks)
    cyc(0, 1, 1, 8'h10);
    cyc(0, 1, 0, 8'h2A);
    rd_sel = 1; #1 snap = rd_data;
    run(64, 1);
    rd_sel = 1; #1 chk(rd_data != snap, "R7 counter advanced at slow rate", rd_data, snap);

    // R10: mask set, counters keep running
    cyc(0, 1, 0, 8'h8E);
    rd_sel = 1; #1 snap = rd_data;
    run(300, 1);
    rd_sel = 1; #1 chk(rd_data != snap, "R10 counter runs while masked", rd_data, snap);

    // R5: long run across a tick-count wrap
    cyc(0, 1, 0, 8'h06);
    run(16500, 1);
    chk(l3_seen >= 1, "R5 level-3 seen", l3_seen, 1);

    // Random mix
    for (int i = 0; i < 30000; i++) begin
      bit we = ($urandom % 40) == 0;
      bit ws = $urandom % 2;
      logic [7:0] wd = 8'($urandom);
      if (!ws && ($urandom % 4 != 0)) wd[1] = 1'b1;
      cyc(($urandom % 4) != 0, we, ws, wd);
    end

    finish_run();
  end
endmodule